// File: doc/BRIEF.md
# Processor Processing-State Controller

This block is the sequencer that keeps track of the processing state of a 32-bit processor core. It tells the core and the bus interface what they are allowed to do at any moment. The core reports decoded stop-type instructions, exception requests (reset, bus error, address error, trace, interrupt), debug entry and resume requests, and one completion handshake for each step of exception processing. The block answers with the current state, a bus-cycle enable, the stopped flag, the cause of the exception being taken, and one strobe per exception step.

Exception processing always runs stacking first, then the vector fetch, then the pipeline refill. It ends when the handler's first instruction starts. A bus or address fault that arrives while an exception is being processed does not nest: it halts the core, and only a reset exception leaves the halted state. The stopped condition is a bus-quiet form of normal state. It ends only through a reset, trace or interrupt exception, or through a debug request.

All interfaces are plain level-sensitive control pins. No data stream crosses the block, so there is no valid/ready handshake. Request inputs are sampled on each rising clock edge, and every output comes from registered state.

Top module: `proc_state_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, the block is in normal state (`proc_state` 0), with `cpu_stopped` 0, `bus_en` 1, all step strobes 0 and `exc_cause` 0. State codes: 0 normal, 1 background, 2 exception, 3 halted.
- R2: `stop_exec` in normal state, with no exception or debug request in the same cycle, sets `cpu_stopped` at the next edge. The state stays normal and `bus_en` drops to 0.
- R3: While stopped, only a reset, trace or interrupt request moves the block to exception state, with `cpu_stopped` cleared. Bus error, address error and a repeated `stop_exec` leave the state, `cpu_stopped` and `bus_en` unchanged.
- R4: On entry to exception state, `step_stack` is asserted. `stack_done` then moves to `step_vector`, `vec_done` moves to `step_refill`, and `handler_start` during refill returns the block to normal. A handshake that arrives outside its own step is ignored, and so are `stop_exec`, trace and interrupt requests during exception state.
- R5: When several requests are pending in normal state, the block takes them in the order reset, bus error, address error, trace, interrupt. `exc_cause` is set to 0, 1, 2, 3 or 4 respectively and is held until the next exception is taken.
- R6: In exception state, a bus or address error with no reset request moves the block to halted, and `exc_cause` is unchanged. A reset request in exception state restarts the sequence at `step_stack` with `exc_cause` 0.
- R7: Halted state ignores every input except a reset request, which moves the block to exception state with cause 0. `bus_en` is 0 while halted.
- R8: `dbg_req` moves the block from normal state (running or stopped) to background state and clears `cpu_stopped`. Any exception request in the same cycle outranks it. In background state only a reset request (to exception) or `dbg_resume` (to normal, running) has an effect.
- R9: `bus_en` is 1 in background state, in exception state and in normal state when not stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the controller |
| stop_exec | input | 1 | A stop-type instruction has executed |
| req_reset | input | 1 | Reset exception request |
| req_buserr | input | 1 | Bus error request |
| req_adderr | input | 1 | Address error request |
| req_trace | input | 1 | Trace exception request |
| req_int | input | 1 | Interrupt exception request |
| dbg_req | input | 1 | Request to enter background (debug) state |
| dbg_resume | input | 1 | Return from background state to normal |
| stack_done | input | 1 | Stacking step complete |
| vec_done | input | 1 | Vector fetch step complete |
| handler_start | input | 1 | Handler's first instruction begins |
| proc_state | output | 2 | Current state code |
| cpu_stopped | output | 1 | Stopped condition of normal state |
| bus_en | output | 1 | Bus cycles may be started |
| step_stack | output | 1 | Stacking step active |
| step_vector | output | 1 | Vector fetch step active |
| step_refill | output | 1 | Pipeline refill step active |
| exc_cause | output | 3 | Cause of the last exception taken |

## Verification
The bench targets the following corner cases. Each line names the case and the faulty behaviour that the bench would report.
- Simultaneous requests: a reversed priority encoder records the wrong cause.
- A bus error while stopped: a design that does not mask it leaves the quiet stopped condition without cause.
- A fault during exception processing: a design that nests the fault restarts stacking instead of halting.
- A reset request in the middle of the sequence: a design that ignores it keeps advancing through the steps.
- Handshakes that arrive in the wrong step: a design that accepts them skips stacking or the vector fetch.
- Debug entry from the stopped condition, and `dbg_resume`: a design that gets these wrong returns with the bus still quiet, or ignores the resume.

// File: rtl/pstate_pkg.sv
package pstate_pkg;

  typedef enum logic [1:0] {
    PS_NORMAL     = 2'd0,
    PS_BACKGROUND = 2'd1,
    PS_EXCEPTION  = 2'd2,
    PS_HALTED     = 2'd3
  } pstate_e;

  typedef enum logic [1:0] {
    XS_STACK  = 2'd0,
    XS_VECTOR = 2'd1,
    XS_REFILL = 2'd2
  } xstep_e;

  // exception sources, index equals priority rank (0 is highest)
  localparam int NUM_SRC     = 5;
  localparam int SRC_RESET   = 0;
  localparam int SRC_BUSERR  = 1;
  localparam int SRC_ADDRERR = 2;
  localparam int SRC_TRACE   = 3;
  localparam int SRC_INT     = 4;
  localparam int CAUSE_W     = $clog2(NUM_SRC);

  // sources allowed to end the stopped condition
  localparam logic [NUM_SRC-1:0] STOP_WAKE_MASK =
    NUM_SRC'((1 << SRC_RESET) | (1 << SRC_TRACE) | (1 << SRC_INT));
  // sources honoured outside normal state
  localparam logic [NUM_SRC-1:0] RESET_ONLY_MASK = NUM_SRC'(1 << SRC_RESET);

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter #(
  parameter int N = 5,
  parameter int W = 3
) (
  input  logic [N-1:0] req,
  input  logic [N-1:0] mask,
  output logic [N-1:0] grant,
  output logic         any,
  output logic [W-1:0] cause
);

  logic [N-1:0] eligible;
  logic [N:0]   seen;

  assign eligible = req & mask;
  assign seen[0]  = 1'b0;

  // fixed priority chain, lower index wins
  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant[i]  = eligible[i] & ~seen[i];
    assign seen[i+1] = seen[i] | eligible[i];
  end

  assign any = seen[N];

  always_comb begin
    cause = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) cause = cause | W'(i);
    end
  end

endmodule

// File: rtl/exc_step_seq.sv
module exc_step_seq
  import pstate_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic active,
  input  logic stack_done,
  input  logic vec_done,
  input  logic handler_start,
  output logic step_stack,
  output logic step_vector,
  output logic step_refill,
  output logic finish
);

  xstep_e step_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q <= XS_STACK;
    end else if (start) begin
      step_q <= XS_STACK;
    end else if (active) begin
      unique case (step_q)
        XS_STACK:  if (stack_done)    step_q <= XS_VECTOR;
        XS_VECTOR: if (vec_done)      step_q <= XS_REFILL;
        XS_REFILL: if (handler_start) step_q <= XS_STACK;
        default:                      step_q <= XS_STACK;
      endcase
    end
  end

  assign step_stack  = active && (step_q == XS_STACK);
  assign step_vector = active && (step_q == XS_VECTOR);
  assign step_refill = active && (step_q == XS_REFILL);
  assign finish      = step_refill && handler_start;

endmodule

// File: rtl/proc_state_ctrl.sv
module proc_state_ctrl
  import pstate_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stop_exec,
  input  logic               req_reset,
  input  logic               req_buserr,
  input  logic               req_adderr,
  input  logic               req_trace,
  input  logic               req_int,
  input  logic               dbg_req,
  input  logic               dbg_resume,
  input  logic               stack_done,
  input  logic               vec_done,
  input  logic               handler_start,
  output logic [1:0]         proc_state,
  output logic               cpu_stopped,
  output logic               bus_en,
  output logic               step_stack,
  output logic               step_vector,
  output logic               step_refill,
  output logic [CAUSE_W-1:0] exc_cause
);

  pstate_e              st_q, st_d;
  logic                 stop_q, stop_d;
  logic [CAUSE_W-1:0]   cause_q, cause_d;
  logic                 seq_start;
  logic                 seq_finish;

  logic [NUM_SRC-1:0]   req_vec;
  logic [NUM_SRC-1:0]   req_mask;
  logic [NUM_SRC-1:0]   grant;
  logic                 take_exc;
  logic [CAUSE_W-1:0]   arb_cause;
  logic                 fault_now;

  always_comb begin
    req_vec              = '0;
    req_vec[SRC_RESET]   = req_reset;
    req_vec[SRC_BUSERR]  = req_buserr;
    req_vec[SRC_ADDRERR] = req_adderr;
    req_vec[SRC_TRACE]   = req_trace;
    req_vec[SRC_INT]     = req_int;
  end

  always_comb begin
    if (st_q == PS_NORMAL) req_mask = stop_q ? STOP_WAKE_MASK : '1;
    else                   req_mask = RESET_ONLY_MASK;
  end

  exc_arbiter #(.N(NUM_SRC), .W(CAUSE_W)) u_arb (
    .req   (req_vec),
    .mask  (req_mask),
    .grant (grant),
    .any   (take_exc),
    .cause (arb_cause)
  );

  assign fault_now = req_buserr | req_adderr;

  always_comb begin
    st_d      = st_q;
    stop_d    = stop_q;
    cause_d   = cause_q;
    seq_start = 1'b0;
    if (take_exc) begin
      st_d      = PS_EXCEPTION;
      stop_d    = 1'b0;
      cause_d   = arb_cause;
      seq_start = 1'b1;
    end else begin
      unique case (st_q)
        PS_NORMAL: begin
          if (dbg_req) begin
            st_d   = PS_BACKGROUND;
            stop_d = 1'b0;
          end else if (stop_exec) begin
            stop_d = 1'b1;
          end
        end
        PS_BACKGROUND: if (dbg_resume) st_d = PS_NORMAL;
        PS_EXCEPTION: begin
          if (fault_now)       st_d = PS_HALTED;
          else if (seq_finish) st_d = PS_NORMAL;
        end
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= PS_NORMAL;
      stop_q  <= 1'b0;
      cause_q <= '0;
    end else begin
      st_q    <= st_d;
      stop_q  <= stop_d;
      cause_q <= cause_d;
    end
  end

  exc_step_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (seq_start),
    .active        (st_q == PS_EXCEPTION),
    .stack_done    (stack_done),
    .vec_done      (vec_done),
    .handler_start (handler_start),
    .step_stack    (step_stack),
    .step_vector   (step_vector),
    .step_refill   (step_refill),
    .finish        (seq_finish)
  );

  assign proc_state  = st_q;
  assign cpu_stopped = stop_q;
  assign bus_en      = !stop_q && (st_q != PS_HALTED);
  assign exc_cause   = cause_q;

endmodule

// File: rtl/proc_state_ctrl_checker.sv
module proc_state_ctrl_checker
  import pstate_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               stop_exec,
  input logic               req_reset,
  input logic               req_buserr,
  input logic               req_adderr,
  input logic               req_trace,
  input logic               req_int,
  input logic               dbg_req,
  input logic               dbg_resume,
  input logic               stack_done,
  input logic               vec_done,
  input logic               handler_start,
  input logic [1:0]         proc_state,
  input logic               cpu_stopped,
  input logic               bus_en,
  input logic               step_stack,
  input logic               step_vector,
  input logic               step_refill,
  input logic [CAUSE_W-1:0] exc_cause
);

  a_r2_stop_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_stopped) |-> $past(stop_exec));

  a_r3_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_stopped && !req_reset && !req_trace && !req_int && !dbg_req |=> cpu_stopped);

  a_r4_steps_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({step_stack, step_vector, step_refill}));

  a_r4_vector_after_stack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(step_vector) |-> $past(step_stack));

  a_r4_refill_after_vector: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(step_refill) |-> $past(step_vector));

  a_r5_reset_first: assert property (@(posedge clk) disable iff (!rst_n)
    req_reset |=> (proc_state == 2'd2) && (exc_cause == '0) && step_stack);

  a_r6_fault_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_state == 2'd2) && !req_reset && (req_buserr || req_adderr) |=> proc_state == 2'd3);

  a_r7_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_state == 2'd3) && !req_reset |=> (proc_state == 2'd3) && !bus_en);

  a_r8_resume: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_state == 2'd1) && dbg_resume && !req_reset |=> proc_state == 2'd0);

endmodule

bind proc_state_ctrl proc_state_ctrl_checker u_chk (.*);

// File: tb/proc_state_ctrl_tb.sv
`timescale 1ns/1ps
module proc_state_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stop_exec = 1'b0;
  logic       req_reset = 1'b0, req_buserr = 1'b0, req_adderr = 1'b0;
  logic       req_trace = 1'b0, req_int = 1'b0;
  logic       dbg_req = 1'b0, dbg_resume = 1'b0;
  logic       stack_done = 1'b0, vec_done = 1'b0, handler_start = 1'b0;
  logic [1:0] proc_state;
  logic       cpu_stopped, bus_en, step_stack, step_vector, step_refill;
  logic [2:0] exc_cause;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  proc_state_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .stop_exec(stop_exec),
    .req_reset(req_reset), .req_buserr(req_buserr), .req_adderr(req_adderr),
    .req_trace(req_trace), .req_int(req_int),
    .dbg_req(dbg_req), .dbg_resume(dbg_resume),
    .stack_done(stack_done), .vec_done(vec_done), .handler_start(handler_start),
    .proc_state(proc_state), .cpu_stopped(cpu_stopped), .bus_en(bus_en),
    .step_stack(step_stack), .step_vector(step_vector), .step_refill(step_refill),
    .exc_cause(exc_cause)
  );

  // entry: {tag, inputs, expected}
  // inputs : stop | reset bus addr trace int | dbg resume sdone vdone hstart
  // expect : state(2) | stopped | bus_en | stack vector refill | cause(3)
  localparam int NV = 52;
  localparam logic [24:0] TBL [NV] = '{
    {4'd1, 11'b0_00000_00000, 10'b00_0_1_000_000}, // R1 idle
    {4'd5, 11'b0_00001_00000, 10'b10_0_1_100_100}, // R5 interrupt
    {4'd4, 11'b0_00000_00100, 10'b10_0_1_010_100}, // R4 stack done
    {4'd4, 11'b0_00001_00010, 10'b10_0_1_001_100}, // R4 vec done, int ignored
    {4'd4, 11'b0_00000_00100, 10'b10_0_1_001_100}, // R4 stray stack done
    {4'd4, 11'b0_00000_00001, 10'b00_0_1_000_100}, // R4 handler start
    {4'd2, 11'b1_00000_00000, 10'b00_1_0_000_100}, // R2 stop
    {4'd3, 11'b0_01000_00000, 10'b00_1_0_000_100}, // R3 bus error masked
    {4'd3, 11'b1_00000_00000, 10'b00_1_0_000_100}, // R3 stop again
    {4'd3, 11'b0_00010_00000, 10'b10_0_1_100_011}, // R3 trace wakes
    {4'd6, 11'b0_01000_00000, 10'b11_0_0_000_011}, // R6 fault halts
    {4'd7, 11'b0_00001_00000, 10'b11_0_0_000_011}, // R7 int ignored
    {4'd7, 11'b0_00000_01000, 10'b11_0_0_000_011}, // R7 resume ignored
    {4'd7, 11'b0_10000_00000, 10'b10_0_1_100_000}, // R7 reset leaves halt
    {4'd4, 11'b0_00000_00100, 10'b10_0_1_010_000}, // R4
    {4'd6, 11'b0_10000_00000, 10'b10_0_1_100_000}, // R6 reset restarts
    {4'd4, 11'b0_00000_00100, 10'b10_0_1_010_000}, // R4
    {4'd4, 11'b0_00000_00010, 10'b10_0_1_001_000}, // R4
    {4'd4, 11'b0_00000_00001, 10'b00_0_1_000_000}, // R4
    {4'd5, 11'b0_00111_00000, 10'b10_0_1_100_010}, // R5 addr over trace/int
    {4'd4, 11'b0_00000_00001, 10'b10_0_1_100_010}, // R4 early hstart
    {4'd4, 11'b0_00000_00010, 10'b10_0_1_100_010}, // R4 early vdone
    {4'd4, 11'b0_00000_00100, 10'b10_0_1_010_010}, // R4
    {4'd4, 11'b0_00000_00010, 10'b10_0_1_001_010}, // R4
    {4'd4, 11'b0_00000_00001, 10'b00_0_1_000_010}, // R4
    {4'd5, 11'b0_01100_00000, 10'b10_0_1_100_001}, // R5 bus over addr
    {4'd6, 11'b0_11000_00000, 10'b10_0_1_100_000}, // R6 reset beats fault
    {4'd4, 11'b1_00000_00100, 10'b10_0_1_010_000}, // R4 stop ignored
    {4'd4, 11'b0_00000_00010, 10'b10_0_1_001_000}, // R4
    {4'd4, 11'b0_00000_00001, 10'b00_0_1_000_000}, // R4
    {4'd8, 11'b1_00000_10000, 10'b01_0_1_000_000}, // R8 dbg beats stop
    {4'd8, 11'b0_01001_00000, 10'b01_0_1_000_000}, // R8 bg ignores
    {4'd8, 11'b0_00000_01000, 10'b00_0_1_000_000}, // R8 resume
    {4'd2, 11'b1_00000_00000, 10'b00_1_0_000_000}, // R2 stop
    {4'd8, 11'b0_00000_10000, 10'b01_0_1_000_000}, // R8 dbg from stopped
    {4'd8, 11'b0_00000_01000, 10'b00_0_1_000_000}, // R8 resume running
    {4'd8, 11'b0_00001_10000, 10'b10_0_1_100_100}, // R8 int beats dbg
    {4'd4, 11'b0_00000_00100, 10'b10_0_1_010_100}, // R4
    {4'd4, 11'b0_00000_00010, 10'b10_0_1_001_100}, // R4
    {4'd4, 11'b0_00000_00001, 10'b00_0_1_000_100}, // R4
    {4'd3, 11'b1_00000_00000, 10'b00_1_0_000_100}, // R3 stop
    {4'd3, 11'b0_10000_00000, 10'b10_0_1_100_000}, // R3 reset wakes
    {4'd6, 11'b0_00100_00000, 10'b11_0_0_000_000}, // R6 addr err halts
    {4'd7, 11'b0_10000_00000, 10'b10_0_1_100_000}, // R7 reset
    {4'd4, 11'b0_00000_00100, 10'b10_0_1_010_000}, // R4
    {4'd4, 11'b0_00000_00010, 10'b10_0_1_001_000}, // R4
    {4'd4, 11'b0_00000_00001, 10'b00_0_1_000_000}, // R4
    {4'd9, 11'b0_00000_10000, 10'b01_0_1_000_000}, // R9 bus on in bg
    {4'd8, 11'b0_10000_00000, 10'b10_0_1_100_000}, // R8 reset in bg
    {4'd4, 11'b0_00000_00100, 10'b10_0_1_010_000}, // R4
    {4'd4, 11'b0_00000_00010, 10'b10_0_1_001_000}, // R4
    {4'd9, 11'b0_00000_00001, 10'b00_0_1_000_000}  // R9 back to normal
  };

  function automatic logic [9:0] observed();
    return {proc_state, cpu_stopped, bus_en, step_stack, step_vector, step_refill, exc_cause};
  endfunction

  task automatic check(input int tag, input logic [9:0] exp);
    logic [9:0] got;
    got = observed();
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL R%0d: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic drive(input logic [10:0] v);
    {stop_exec, req_reset, req_buserr, req_adderr, req_trace, req_int,
     dbg_req, dbg_resume, stack_done, vec_done, handler_start} = v;
  endtask

  initial begin
    #(4 * 100000);
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    drive('0);
    repeat (3) @(negedge clk);
    check(1, 10'b00_0_1_000_000); // R1 during reset
    rst_n = 1'b1;
    @(posedge clk); #1;
    check(1, 10'b00_0_1_000_000); // R1 after release

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(TBL[i][20:10]);
      @(posedge clk); #1;
      check(int'(TBL[i][24:21]), TBL[i][9:0]);
    end

    // R1: controller reset from the stopped condition
    @(negedge clk); drive(11'b1_00000_00000);
    @(posedge clk); #1;
    check(2, 10'b00_1_0_000_000); // R2
    @(negedge clk); drive('0); rst_n = 1'b0;
    @(posedge clk); #1;
    check(1, 10'b00_0_1_000_000); // R1
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check(1, 10'b00_0_1_000_000); // R1

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule